// File: doc/BRIEF.md
# Host Bridge Control Registers, Byte-Lane Swapper and Interrupt Combiner

This block sits between a host bus and a PCI bus and carries two small control registers. The mode register chooses how 32-bit data crosses the bridge. One code value selects big-endian operation, in which the four byte lanes of every word are reversed. Every other code lets data pass unchanged. The enable register decides whether PCI interrupts reach the host at all.

Data moves through two independent swap paths, one from the host to PCI and one from PCI to the host. Each path carries a word and its byte enables. When the lanes are reversed, the byte enables are mirrored with them, so each enable stays attached to its byte.

The four active-low PCI interrupt lines are first brought into the bridge clock domain. They are then OR-ed together, and the result is gated by the enable register. A single flop drives the combined host interrupt. There is no status register and no acknowledge register. The host interrupt falls only when every source has released its line or when forwarding is switched off.

Top module: `pcib_ctl_top`

## Requirements
- R1: After reset, the mode register and the enable register both read 0x00, `host_irq` is 0, and both data paths pass words and byte enables through unchanged.
- R2: A write (`reg_wr` high at a rising edge) to offset 0x0000 stores `reg_wdata` in the mode register. From the next edge on, that offset reads back the stored value through `reg_rdata`.
- R3: A write to offset 0x0010 stores `reg_wdata` in the enable register. From the next edge on, that offset reads back the stored value.
- R4: While the mode register holds 0x02, host-to-PCI output byte lane i (bits 8i+7..8i) equals input byte lane 3-i.
- R5: While the mode register holds 0x02, PCI-to-host output byte lane i equals input byte lane 3-i.
- R6: While the mode register holds 0x02, byte enable output bit i equals input bit 3-i, on both paths.
- R7: While the mode register holds any value other than 0x02 (for example 0x00, 0x01, 0x03 or 0x82), data and byte enables pass through unchanged on both paths.
- R8: A write to an offset other than 0x0000 or 0x0010 changes neither register. A read of such an offset returns 0x00.
- R9: The `pci_int_n` bits are active low. When forwarding is on (enable register holds 0x01) and any bit is driven low before rising edge k, `host_irq` is still 0 after edges k and k+1 and is 1 after edge k+2.
- R10: While the enable register holds any value other than 0x01, `host_irq` stays 0 whatever the state of `pci_int_n`.
- R11: `host_irq` stays 1 as long as at least one source is low and forwarding is on. It falls to 0 two edges after the last source returns high.
- R12: A write that changes the enable register at edge k leaves `host_irq` unchanged after edge k and shows the new gated value after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset for both read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` (combinational) |
| h2p_data_in | input | 32 | Word arriving from the host |
| h2p_be_in | input | 4 | Byte enables arriving from the host |
| h2p_data_out | output | 32 | Word sent toward PCI |
| h2p_be_out | output | 4 | Byte enables sent toward PCI |
| p2h_data_in | input | 32 | Word arriving from PCI |
| p2h_be_in | input | 4 | Byte enables arriving from PCI |
| p2h_data_out | output | 32 | Word sent toward the host |
| p2h_be_out | output | 4 | Byte enables sent toward the host |
| pci_int_n | input | 4 | PCI interrupt lines A to D, active low, asynchronous |
| host_irq | output | 1 | Combined host interrupt, active high, registered |

## Verification
The bench builds the block with its default parameters: 32-bit words split into four 8-bit lanes, four interrupt lines, two synchronizer stages and a 16-bit offset. These values put the exact edge-by-edge latency of a raw interrupt within reach: two synchronizer flops plus the output flop give three edges. They also put the mirrored byte-enable patterns within reach. The bench checks how the swapper decodes non-matching mode codes, and it overlaps interrupt sources so that one source can release while another still holds the host line.

// File: rtl/pcib_ctl_pkg.sv
package pcib_ctl_pkg;

  localparam int unsigned CTL_ADDR_W = 16;
  localparam int unsigned CTL_REG_W  = 8;

  localparam logic [CTL_ADDR_W-1:0] OFF_MODE = 16'h0000;
  localparam logic [CTL_ADDR_W-1:0] OFF_IEN  = 16'h0010;

  localparam logic [CTL_REG_W-1:0] MODE_BIG_ENDIAN = 8'h02;
  localparam logic [CTL_REG_W-1:0] IEN_FORWARD     = 8'h01;

  typedef struct packed {
    logic [CTL_REG_W-1:0] mode;
    logic [CTL_REG_W-1:0] ien;
  } ctl_regs_t;

  // Swap is active only for the exact big-endian code.
  function automatic logic mode_is_big(input logic [CTL_REG_W-1:0] m);
    return (m == MODE_BIG_ENDIAN);
  endfunction

  // Forwarding is active only for the exact enable code.
  function automatic logic ien_is_on(input logic [CTL_REG_W-1:0] e);
    return (e == IEN_FORWARD);
  endfunction

endpackage

// File: rtl/pcib_ctl_regs.sv
module pcib_ctl_regs
  import pcib_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W = CTL_ADDR_W,
  parameter int unsigned REG_W  = CTL_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [REG_W-1:0]  mode_q,
  output logic [REG_W-1:0]  ien_q
);

  logic hit_mode;
  logic hit_ien;
  logic wr_mode;
  logic wr_ien;

  assign hit_mode = (addr == ADDR_W'(OFF_MODE));
  assign hit_ien  = (addr == ADDR_W'(OFF_IEN));
  assign wr_mode  = wr_stb && hit_mode;
  assign wr_ien   = wr_stb && hit_ien;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_mode) mode_q <= wdata;
      if (wr_ien)  ien_q  <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_mode)     rdata = mode_q;
    else if (hit_ien) rdata = ien_q;
  end

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mode |=> (mode_q == $past(wdata)));                 // R2
  AST_IEN_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ien |=> (ien_q == $past(wdata)));                   // R3
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mode |=> $stable(mode_q));                         // R8
  AST_IEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ien |=> $stable(ien_q));                           // R8

endmodule

// File: rtl/pcib_lane_swap.sv
module pcib_lane_swap #(
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             swap_en,
  input  logic [DW-1:0]    data_in,
  input  logic [LANES-1:0] be_in,
  output logic [DW-1:0]    data_out,
  output logic [LANES-1:0] be_out
);

  logic [DW-1:0]    data_rev;
  logic [LANES-1:0] be_rev;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign data_rev[i*LANE_W +: LANE_W] = data_in[(LANES-1-i)*LANE_W +: LANE_W];
    assign be_rev[i]                    = be_in[LANES-1-i];
  end

  assign data_out = swap_en ? data_rev : data_in;
  assign be_out   = swap_en ? be_rev   : be_in;

endmodule

// File: rtl/pcib_irq_merge.sv
module pcib_irq_merge #(
  parameter int unsigned NUM_IRQ     = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fwd_en,
  input  logic [NUM_IRQ-1:0] irq_n_raw,
  output logic               irq_out
);

  logic [NUM_IRQ-1:0] sync_q [SYNC_STAGES];
  logic [NUM_IRQ-1:0] src_act;
  logic               any_act;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[s] <= '1;
      else if (s == 0) sync_q[s] <= irq_n_raw;
      else sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  assign src_act = ~sync_q[SYNC_STAGES-1];
  assign any_act = |src_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_out <= 1'b0;
    else        irq_out <= fwd_en && any_act;
  end

  AST_IRQ_GATED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd_en |=> !irq_out);                                 // R10
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_en && any_act) |=> irq_out);                      // R9
  AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !any_act |=> !irq_out);                                // R11

endmodule

// File: rtl/pcib_ctl_top.sv
module pcib_ctl_top
  import pcib_ctl_pkg::*;
#(
  parameter int unsigned LANES       = 4,
  parameter int unsigned LANE_W      = 8,
  parameter int unsigned NUM_IRQ     = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_W      = CTL_ADDR_W,
  parameter int unsigned REG_W       = CTL_REG_W,
  localparam int unsigned DW         = LANES * LANE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [REG_W-1:0]   reg_wdata,
  output logic [REG_W-1:0]   reg_rdata,
  input  logic [DW-1:0]      h2p_data_in,
  input  logic [LANES-1:0]   h2p_be_in,
  output logic [DW-1:0]      h2p_data_out,
  output logic [LANES-1:0]   h2p_be_out,
  input  logic [DW-1:0]      p2h_data_in,
  input  logic [LANES-1:0]   p2h_be_in,
  output logic [DW-1:0]      p2h_data_out,
  output logic [LANES-1:0]   p2h_be_out,
  input  logic [NUM_IRQ-1:0] pci_int_n,
  output logic               host_irq
);

  ctl_regs_t regs;
  logic      big_mode;
  logic      fwd_on;

  pcib_ctl_regs #(.ADDR_W(ADDR_W), .REG_W(REG_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_stb (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .mode_q (regs.mode),
    .ien_q  (regs.ien)
  );

  assign big_mode = mode_is_big(regs.mode);
  assign fwd_on   = ien_is_on(regs.ien);

  pcib_lane_swap #(.LANES(LANES), .LANE_W(LANE_W)) u_swap_h2p (
    .swap_en  (big_mode),
    .data_in  (h2p_data_in),
    .be_in    (h2p_be_in),
    .data_out (h2p_data_out),
    .be_out   (h2p_be_out)
  );

  pcib_lane_swap #(.LANES(LANES), .LANE_W(LANE_W)) u_swap_p2h (
    .swap_en  (big_mode),
    .data_in  (p2h_data_in),
    .be_in    (p2h_be_in),
    .data_out (p2h_data_out),
    .be_out   (p2h_be_out)
  );

  pcib_irq_merge #(.NUM_IRQ(NUM_IRQ), .SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd_en    (fwd_on),
    .irq_n_raw (pci_int_n),
    .irq_out   (host_irq)
  );

  AST_BE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(h2p_be_out) == $countones(h2p_be_in));      // R6
  AST_PASS_H2P: assert property (@(posedge clk) disable iff (!rst_n)
    !big_mode |-> (h2p_data_out == h2p_data_in));          // R7
  AST_PASS_P2H: assert property (@(posedge clk) disable iff (!rst_n)
    !big_mode |-> (p2h_data_out == p2h_data_in));          // R7
  AST_SWAP_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    big_mode |-> (p2h_data_out[LANE_W-1:0] == p2h_data_in[DW-1 -: LANE_W])); // R5

endmodule

// File: tb/pcib_ctl_top_tb_top.sv
module pcib_ctl_top_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef enum int {K_H2P_D, K_H2P_BE, K_P2H_D, K_P2H_BE, K_RDATA, K_IRQ} kind_e;
  typedef struct {
    kind_e       kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic [31:0] h2p_data_in = '0, h2p_data_out, p2h_data_in = '0, p2h_data_out;
  logic [3:0]  h2p_be_in = '0, h2p_be_out, p2h_be_in = '0, p2h_be_out;
  logic [3:0]  pci_int_n = 4'hF;
  logic        host_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  pcib_ctl_top dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .h2p_data_in(h2p_data_in), .h2p_be_in(h2p_be_in),
    .h2p_data_out(h2p_data_out), .h2p_be_out(h2p_be_out),
    .p2h_data_in(p2h_data_in), .p2h_be_in(p2h_be_in),
    .p2h_data_out(p2h_data_out), .p2h_be_out(p2h_be_out),
    .pci_int_n(pci_int_n), .host_irq(host_irq)
  );

  function automatic logic [31:0] flip_word(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic logic [3:0] flip_be(input logic [3:0] b);
    return {b[0], b[1], b[2], b[3]};
  endfunction

  // Monitor: pops expected items and compares them against the live outputs.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb_q.pop_front();
        case (it.kind)
          K_H2P_D:  act = h2p_data_out;
          K_H2P_BE: act = {28'd0, h2p_be_out};
          K_P2H_D:  act = p2h_data_out;
          K_P2H_BE: act = {28'd0, p2h_be_out};
          K_RDATA:  act = {24'd0, reg_rdata};
          default:  act = {31'd0, host_irq};
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input kind_e k, input logic [31:0] e, input string tag);
    item_t it;
    it.kind = k; it.exp = e; it.tag = tag;
    sb_q.push_back(it);
    wait (sb_q.size() == 0);
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [15:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    expect_item(K_RDATA, {24'd0, e}, tag);
  endtask

  task automatic data_check(input logic [31:0] hd, input logic [3:0] hb,
                            input logic [31:0] pd, input logic [3:0] pb,
                            input bit big, input string tag);
    @(negedge clk);
    h2p_data_in = hd; h2p_be_in = hb; p2h_data_in = pd; p2h_be_in = pb;
    expect_item(K_H2P_D,  big ? flip_word(hd) : hd, {tag, " h2p data"});
    expect_item(K_H2P_BE, {28'd0, big ? flip_be(hb) : hb}, {tag, " h2p be"});
    expect_item(K_P2H_D,  big ? flip_word(pd) : pd, {tag, " p2h data"});
    expect_item(K_P2H_BE, {28'd0, big ? flip_be(pb) : pb}, {tag, " p2h be"});
  endtask

  // Drive interrupt lines and check host_irq: old value after two edges, new after three.
  task automatic irq_step(input logic [3:0] lines, input bit old_v, input bit new_v, input string tag);
    @(negedge clk);
    pci_int_n = lines;
    repeat (2) @(posedge clk);
    @(negedge clk);
    expect_item(K_IRQ, {31'd0, old_v}, {tag, " before latency"});
    @(posedge clk);
    @(negedge clk);
    expect_item(K_IRQ, {31'd0, new_v}, {tag, " after latency"});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_read(16'h0000, 8'h00, "R1 mode reset");
    reg_read(16'h0010, 8'h00, "R1 ien reset");
    expect_item(K_IRQ, 32'd0, "R1 irq reset");
    data_check(32'h11223344, 4'b0011, 32'hA1B2C3D4, 4'b0001, 0, "R1 passthrough");

    // R2 / R4 / R5 / R6 big-endian
    reg_write(16'h0000, 8'h02);
    reg_read(16'h0000, 8'h02, "R2 mode readback");
    data_check(32'h11223344, 4'b0011, 32'hA1B2C3D4, 4'b0001, 1, "R4 R5 R6 swap a");
    data_check(32'hDEADBEEF, 4'b1000, 32'h01020304, 4'b0110, 1, "R4 R5 R6 swap b");

    // R8 other offsets ignored
    reg_write(16'h0004, 8'h00);
    reg_write(16'h0011, 8'h01);
    reg_read(16'h0000, 8'h02, "R8 mode untouched");
    reg_read(16'h0010, 8'h00, "R8 ien untouched");
    reg_read(16'h0004, 8'h00, "R8 unmapped read");
    data_check(32'hCAFEF00D, 4'b1110, 32'h89ABCDEF, 4'b0100, 1, "R8 still swapping");

    // R7 non-matching codes
    reg_write(16'h0000, 8'h01);
    data_check(32'h11223344, 4'b0011, 32'hA1B2C3D4, 4'b0001, 0, "R7 mode 01");
    reg_write(16'h0000, 8'h03);
    data_check(32'h55667788, 4'b1000, 32'h99AABBCC, 4'b0010, 0, "R7 mode 03");
    reg_write(16'h0000, 8'h82);
    reg_read(16'h0000, 8'h82, "R2 mode readback 82");
    data_check(32'h0F1E2D3C, 4'b0001, 32'h4B5A6978, 4'b1100, 0, "R7 mode 82");

    // R10 disabled: source active, no irq
    irq_step(4'b1110, 0, 0, "R10 disabled INTA");
    reg_write(16'h0010, 8'h03);
    reg_read(16'h0010, 8'h03, "R3 ien readback 03");
    repeat (3) @(posedge clk);
    @(negedge clk);
    expect_item(K_IRQ, 32'd0, "R10 ien 03 stays off");
    irq_step(4'b1111, 0, 0, "R10 release");

    // R12 enable timing
    @(negedge clk); pci_int_n = 4'b1011;
    repeat (3) @(posedge clk);
    reg_write(16'h0010, 8'h01);
    expect_item(K_IRQ, 32'd0, "R12 irq one edge after enable write");
    @(posedge clk); @(negedge clk);
    expect_item(K_IRQ, 32'd1, "R12 irq two edges after enable write");
    reg_read(16'h0010, 8'h01, "R3 ien readback 01");

    // R11 overlapping sources
    irq_step(4'b1001, 1, 1, "R11 second source");
    irq_step(4'b1101, 1, 1, "R11 first release");
    irq_step(4'b1111, 1, 0, "R11 last release");

    // R9 latency on other lines
    irq_step(4'b0111, 0, 1, "R9 INTD");
    irq_step(4'b1111, 1, 0, "R11 INTD release");
    irq_step(4'b1101, 0, 1, "R9 INTB");

    // R12 disable while active
    reg_write(16'h0010, 8'h00);
    expect_item(K_IRQ, 32'd1, "R12 irq one edge after disable");
    @(posedge clk); @(negedge clk);
    expect_item(K_IRQ, 32'd0, "R12 irq off after disable");

    // R1 reset again clears state
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1; pci_int_n = 4'hF;
    reg_read(16'h0000, 8'h00, "R1 mode after re-reset");
    expect_item(K_IRQ, 32'd0, "R1 irq after re-reset");

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule